// File: doc/BRIEF.md
# Bit-Serial Feistel Encryption Core

This block encrypts one block of a lightweight Feistel cipher one bit per clock. It keeps the two message halves and the four key words in single-bit shift registers. Each clock it produces one bit of the new left half and one bit of the next key word. A round over an n-bit word therefore takes n clocks. The word size n is a parameter (16, 24 or 32). The block is 2n bits wide, the key is 4n bits wide, and the round count follows from n.

A single mode input drives the core. While the mode is high, one plaintext bit and one key bit are shifted in on every clock. When the mode goes low, encryption runs through every round. The 2n ciphertext bits are then shifted out under a valid flag, after which the core sits idle. Raising the mode at any time abandons the current work and starts a new load.

Top module: `serial_feistel_enc`

## Requirements
- R1: After reset, o_valid and o_text_bit are 0. While i_mode stays low with no load since reset, o_valid stays 0.
- R2: Loading shifts bits in on every clock with i_mode high, least significant bit first. The text register keeps the last 2n bits of i_text_bit as the word {x, y}, with x in the upper half. The key register keeps the last 4n bits of i_key_bit as {t3, t2, t1, t0}, with t0 in the low word.
- R3: Each round maps (x, y) to (y ^ (x & rotl(x,5)) ^ rotl(x,1) ^ k, x), where k is the current round key.
- R4: The round key of round i is t_i. The schedule forms t_{i+4} = t_i ^ (t_{i+1} & rotl(t_{i+1},5)) ^ rotl(t_{i+1},1) ^ C ^ z(i). C is 2^n − 4, and z(i) sits in bit 0.
- R5: z(i) is bit s[0] of a shift register reseeded to all ones on every load clock. After each round the register shifts right by one, and a new top bit is inserted. That bit is s[0]^s[2] with a 5-bit register for n = 16 or 24, and s[0]^s[1] with a 6-bit register for n = 32.
- R6: The round count is 32, 36 or 44 for n = 16, 24 or 32. o_valid first goes high after the (rounds·n + 1)-th rising edge that samples i_mode low following a load.
- R7: o_valid stays high for exactly 2n cycles. During those cycles o_text_bit carries the ciphertext {x, y}, least significant bit first. o_text_bit is 0 whenever o_valid is 0.
- R8: A rising edge that samples i_mode high ends any run or output burst, so o_valid is 0 after that edge. The next load then encrypts correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_mode | input | 1 | 1: shift in text and key bits; 0: process |
| i_text_bit | input | 1 | Serial plaintext bit |
| i_key_bit | input | 1 | Serial key bit |
| o_valid | output | 1 | Ciphertext bit is valid |
| o_text_bit | output | 1 | Serial ciphertext bit |

## Verification
Some properties are checked on every cycle. The run lasts exactly rounds·n clocks before output starts. An uninterrupted burst is exactly 2n cycles long. A load clock clears the valid flag. The constant register never reaches zero and only moves at a round boundary or a load. Whether the tap multiplexers pick the right bit, and whether the constant sequence and key ordering are right, shows only in the ciphertext. The bench compares that ciphertext with a word-level model for all three word sizes, using loads that carry filler bits and aborts placed in both the round phase and the output phase.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_RUN   = 2'd2,
        ST_SHOUT = 2'd3
    } sfe_state_e;

    // Per-clock control bundle from the sequencer to the datapaths
    typedef struct packed {
        logic shift_in;  // serial load clock
        logic step;      // one round bit is computed
        logic drain;     // ciphertext shifts out
        logic near1;     // bit 0: rotate-by-1 source still in the word being consumed
        logic near5;     // bits 0..4: rotate-by-5 source still in the word being consumed
        logic cbit;      // constant bit C[l] (without sequence bit)
        logic zsel;      // bit 0: sequence bit is applied
        logic adv;       // last bit of a round
        logic reseed;    // constant register back to all ones
    } sfe_ctl_t;

    function automatic int rounds_for(input int n);
        if (n <= 16) return 32;
        if (n <= 24) return 36;
        return 44;
    endfunction

    function automatic int lfsr_width(input int n);
        return (n >= 32) ? 6 : 5;
    endfunction

    function automatic int lfsr_tap(input int n);
        return (n >= 32) ? 1 : 2;
    endfunction

    // Nonlinear mixing of one bit: AND with far tap, XOR near tap
    function automatic logic mix_bit(input logic cur, input logic far5, input logic far1);
        return (cur & far5) ^ far1;
    endfunction

endpackage

// File: rtl/sfe_ctrl.sv
module sfe_ctrl
    import sfe_pkg::*;
#(
    parameter int WORD   = 16,
    parameter int ROUNDS = 32
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     i_mode,
    output sfe_ctl_t o_ctl,
    output logic     o_valid
);
    localparam int CW  = $clog2(WORD);
    localparam int RW  = $clog2(ROUNDS);
    localparam int OW  = $clog2(2 * WORD);
    localparam int RLW = $clog2(ROUNDS * WORD + 1);
    localparam logic [CW-1:0] BIT_LAST = CW'(WORD - 1);
    localparam logic [RW-1:0] RND_LAST = RW'(ROUNDS - 1);
    localparam logic [OW-1:0] OUT_LAST = OW'(2 * WORD - 1);

    sfe_state_e    state_q;
    logic [CW-1:0] bit_q;
    logic [RW-1:0] rnd_q;
    logic [OW-1:0] out_q;
    logic          last_bit;
    logic          last_rnd;
    logic          last_out;

    assign last_bit = (bit_q == BIT_LAST);
    assign last_rnd = (rnd_q == RND_LAST);
    assign last_out = (out_q == OUT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            rnd_q   <= '0;
            out_q   <= '0;
        end else if (i_mode) begin
            state_q <= ST_LOAD;
            bit_q   <= '0;
            rnd_q   <= '0;
            out_q   <= '0;
        end else begin
            case (state_q)
                ST_LOAD: state_q <= ST_RUN;
                ST_RUN: begin
                    if (last_bit) begin
                        bit_q <= '0;
                        if (last_rnd) begin
                            rnd_q   <= '0;
                            state_q <= ST_SHOUT;
                        end else begin
                            rnd_q <= rnd_q + 1'b1;
                        end
                    end else begin
                        bit_q <= bit_q + 1'b1;
                    end
                end
                ST_SHOUT: begin
                    if (last_out) begin
                        out_q   <= '0;
                        state_q <= ST_IDLE;
                    end else begin
                        out_q <= out_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        o_ctl.shift_in = i_mode;
        o_ctl.step     = (state_q == ST_RUN) && !i_mode;
        o_ctl.drain    = (state_q == ST_SHOUT) && !i_mode;
        o_ctl.near1    = (bit_q == '0);
        o_ctl.near5    = (bit_q < CW'(5));
        o_ctl.cbit     = (bit_q >= CW'(2));
        o_ctl.zsel     = (bit_q == '0);
        o_ctl.adv      = (state_q == ST_RUN) && !i_mode && last_bit;
        o_ctl.reseed   = i_mode;
    end

    assign o_valid = (state_q == ST_SHOUT);

    // Checker: count clocks spent computing
    logic [RLW-1:0] run_len_q;
    always_ff @(posedge clk) begin
        if (rst) run_len_q <= '0;
        else if (state_q == ST_RUN && !i_mode) run_len_q <= run_len_q + 1'b1;
        else run_len_q <= '0;
    end

    // R6: output phase is entered only after exactly rounds*n compute clocks
    a_r6_run_length: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) == ST_RUN && state_q == ST_SHOUT) |-> (run_len_q == RLW'(ROUNDS * WORD)));

    // R6: a round boundary returns the bit position to 0 and stays computing
    a_r6_round_wrap: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && !i_mode && last_bit && !last_rnd) |=> (state_q == ST_RUN && bit_q == '0));

endmodule

// File: rtl/sfe_const.sv
module sfe_const
    import sfe_pkg::*;
#(
    parameter int WORD = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic i_reseed,
    input  logic i_adv,
    output logic o_z
);
    localparam int LW  = lfsr_width(WORD);
    localparam int TAP = lfsr_tap(WORD);

    logic [LW-1:0] lfsr_q;

    always_ff @(posedge clk) begin
        if (rst || i_reseed) lfsr_q <= '1;
        else if (i_adv)      lfsr_q <= {lfsr_q[0] ^ lfsr_q[TAP], lfsr_q[LW-1:1]};
    end

    assign o_z = lfsr_q[0];

    // R5: primitive feedback never reaches the all-zero state
    a_r5_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != '0);

    // R5: the sequence moves once per round, never per bit
    a_r5_hold_inside_round: assert property (@(posedge clk) disable iff (rst)
        (!i_adv && !i_reseed) |=> $stable(lfsr_q));

endmodule

// File: rtl/sfe_taps.sv
module sfe_taps #(
    parameter int WORD = 16
) (
    input  logic [WORD-1:0] i_cur,   // word being consumed this round
    input  logic [WORD-1:0] i_done,  // register receiving consumed bits
    input  logic            i_near1,
    input  logic            i_near5,
    output logic            o_far1,
    output logic            o_far5
);
    // Before the source bit has left i_cur it is found at the top of i_cur;
    // afterwards it sits at the same offset in the receiving register.
    assign o_far1 = i_near1 ? i_cur[WORD-1] : i_done[WORD-1];
    assign o_far5 = i_near5 ? i_cur[WORD-5] : i_done[WORD-5];
endmodule

// File: rtl/sfe_keysched.sv
module sfe_keysched
    import sfe_pkg::*;
#(
    parameter int WORD = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic i_shift_in,
    input  logic i_step,
    input  logic i_near1,
    input  logic i_near5,
    input  logic i_cbit,
    input  logic i_zsel,
    input  logic i_key_bit,
    input  logic i_z,
    output logic o_rk
);
    localparam int NW = 4;

    logic [NW-1:0][WORD-1:0] kw_q;   // kw_q[0] holds the current round key
    logic far1, far5, cst, knew, top_in;

    sfe_taps #(.WORD(WORD)) u_taps (
        .i_cur  (kw_q[1]),
        .i_done (kw_q[0]),
        .i_near1(i_near1),
        .i_near5(i_near5),
        .o_far1 (far1),
        .o_far5 (far5)
    );

    always_comb begin
        cst    = i_cbit ^ (i_zsel & i_z);
        knew   = kw_q[0][0] ^ mix_bit(kw_q[1][0], far5, far1) ^ cst;
        top_in = i_shift_in ? i_key_bit : knew;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kw_q <= '0;
        end else if (i_shift_in || i_step) begin
            kw_q[NW-1] <= {top_in, kw_q[NW-1][WORD-1:1]};
            for (int w = 0; w < NW - 1; w++)
                kw_q[w] <= {kw_q[w+1][0], kw_q[w][WORD-1:1]};
        end
    end

    assign o_rk = kw_q[0][0];

endmodule

// File: rtl/sfe_textpath.sv
module sfe_textpath
    import sfe_pkg::*;
#(
    parameter int WORD = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic i_shift_in,
    input  logic i_step,
    input  logic i_drain,
    input  logic i_near1,
    input  logic i_near5,
    input  logic i_text_bit,
    input  logic i_rk,
    output logic o_lsb
);
    logic [WORD-1:0] xw_q, yw_q;
    logic far1, far5, xnew, top_in;

    sfe_taps #(.WORD(WORD)) u_taps (
        .i_cur  (xw_q),
        .i_done (yw_q),
        .i_near1(i_near1),
        .i_near5(i_near5),
        .o_far1 (far1),
        .o_far5 (far5)
    );

    always_comb begin
        xnew = yw_q[0] ^ mix_bit(xw_q[0], far5, far1) ^ i_rk;
        if (i_shift_in)  top_in = i_text_bit;
        else if (i_step) top_in = xnew;
        else             top_in = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            xw_q <= '0;
            yw_q <= '0;
        end else if (i_shift_in || i_step || i_drain) begin
            xw_q <= {top_in, xw_q[WORD-1:1]};
            yw_q <= {xw_q[0], yw_q[WORD-1:1]};
        end
    end

    assign o_lsb = yw_q[0];

endmodule

// File: rtl/serial_feistel_enc.sv
module serial_feistel_enc
    import sfe_pkg::*;
#(
    parameter int WORD = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic i_mode,
    input  logic i_text_bit,
    input  logic i_key_bit,
    output logic o_valid,
    output logic o_text_bit
);
    localparam int ROUNDS = rounds_for(WORD);
    localparam int BW     = $clog2(2 * WORD + 1);

    sfe_ctl_t ctl;
    logic     z_bit, rk_bit, lsb;

    sfe_ctrl #(.WORD(WORD), .ROUNDS(ROUNDS)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .i_mode (i_mode),
        .o_ctl  (ctl),
        .o_valid(o_valid)
    );

    sfe_const #(.WORD(WORD)) u_const (
        .clk     (clk),
        .rst     (rst),
        .i_reseed(ctl.reseed),
        .i_adv   (ctl.adv),
        .o_z     (z_bit)
    );

    sfe_keysched #(.WORD(WORD)) u_keys (
        .clk       (clk),
        .rst       (rst),
        .i_shift_in(ctl.shift_in),
        .i_step    (ctl.step),
        .i_near1   (ctl.near1),
        .i_near5   (ctl.near5),
        .i_cbit    (ctl.cbit),
        .i_zsel    (ctl.zsel),
        .i_key_bit (i_key_bit),
        .i_z       (z_bit),
        .o_rk      (rk_bit)
    );

    sfe_textpath #(.WORD(WORD)) u_text (
        .clk       (clk),
        .rst       (rst),
        .i_shift_in(ctl.shift_in),
        .i_step    (ctl.step),
        .i_drain   (ctl.drain),
        .i_near1   (ctl.near1),
        .i_near5   (ctl.near5),
        .i_text_bit(i_text_bit),
        .i_rk      (rk_bit),
        .o_lsb     (lsb)
    );

    assign o_text_bit = o_valid & lsb;

    // Checker: length of the current valid burst
    logic [BW-1:0] burst_q;
    always_ff @(posedge clk) begin
        if (rst)          burst_q <= '0;
        else if (o_valid) burst_q <= burst_q + 1'b1;
        else              burst_q <= '0;
    end

    // R7: an uninterrupted burst carries exactly 2n bits
    a_r7_burst_len: assert property (@(posedge clk) disable iff (rst)
        (!o_valid && burst_q != '0 && !$past(i_mode)) |-> (burst_q == BW'(2 * WORD)));

    // R8: a load clock always ends output
    a_r8_abort_clears: assert property (@(posedge clk) disable iff (rst)
        i_mode |=> !o_valid);

endmodule

// File: tb/serial_feistel_enc_bench.sv
`timescale 1ns/1ps
module serial_feistel_enc_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic tbit [3];
    logic kbit [3];
    logic v    [3];
    logic ob   [3];
    int   nsz  [3] = '{16, 24, 32};

    serial_feistel_enc #(.WORD(16)) u_serial_feistel_enc (
        .clk(clk), .rst(rst), .i_mode(mode), .i_text_bit(tbit[0]), .i_key_bit(kbit[0]),
        .o_valid(v[0]), .o_text_bit(ob[0]));
    serial_feistel_enc #(.WORD(24)) u_serial_feistel_enc_w24 (
        .clk(clk), .rst(rst), .i_mode(mode), .i_text_bit(tbit[1]), .i_key_bit(kbit[1]),
        .o_valid(v[1]), .o_text_bit(ob[1]));
    serial_feistel_enc #(.WORD(32)) u_serial_feistel_enc_w32 (
        .clk(clk), .rst(rst), .i_mode(mode), .i_text_bit(tbit[2]), .i_key_bit(kbit[2]),
        .o_valid(v[2]), .o_text_bit(ob[2]));

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam int NV = 5;
    localparam logic [63:0] TXT [NV] = '{
        64'h0000_0000_0000_0000,
        64'hFFFF_FFFF_FFFF_FFFF,
        64'h6565_6877_0123_4567,
        64'hDEAD_BEEF_8000_0001,
        64'h1357_9BDF_2468_ACE0
    };
    localparam logic [127:0] KEY [NV] = '{
        128'h0,
        128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
        128'h1B1A_1918_1312_1110_0B0A_0908_0302_0100,
        128'h0000_0000_0000_0001_8000_0000_0000_0000,
        128'hA5A5_5A5A_0F0F_F0F0_3C3C_C3C3_9696_6969
    };

    logic [63:0] cap [3];
    int          cnt [3];
    int          lat [3];

    // Collect serial output
    always @(negedge clk) begin
        for (int i = 0; i < 3; i++) begin
            if (v[i]) begin
                if (cnt[i] < 64) cap[i][cnt[i]] = ob[i];
                cnt[i]++;
            end
        end
    end

    // Word-level model
    function automatic logic [63:0] rotl(input logic [63:0] x, input int r, input int n);
        logic [63:0] m;
        m = (64'd1 << n) - 64'd1;
        return ((x << r) | (x >> (n - r))) & m;
    endfunction

    function automatic logic [63:0] fmix(input logic [63:0] x, input int n);
        return (x & rotl(x, 5, n)) ^ rotl(x, 1, n);
    endfunction

    function automatic logic [63:0] ref_enc(input int n, input logic [63:0] pt, input logic [127:0] key);
        logic [63:0] m, x, y, tmp, cst, tn;
        logic [63:0] t [4];
        logic [5:0]  s;
        logic        z, fb;
        int          nr;
        m   = (64'd1 << n) - 64'd1;
        x   = (pt >> n) & m;
        y   = pt & m;
        for (int i = 0; i < 4; i++) t[i] = 64'(key >> (i * n)) & m;
        cst = m ^ 64'd3;
        s   = (n == 32) ? 6'h3F : 6'h1F;
        nr  = (n == 16) ? 32 : (n == 24) ? 36 : 44;
        for (int r = 0; r < nr; r++) begin
            z   = s[0];
            tmp = x;
            x   = y ^ fmix(x, n) ^ t[0];
            y   = tmp;
            tn  = t[0] ^ fmix(t[1], n) ^ cst ^ {63'd0, z};
            t[0] = t[1]; t[1] = t[2]; t[2] = t[3]; t[3] = tn;
            if (n == 32) begin
                fb = s[0] ^ s[1];
                s  = {fb, s[5:1]};
            end else begin
                fb = s[0] ^ s[2];
                s  = {1'b0, fb, s[4:1]};
            end
        end
        return (x << n) | y;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Serial load of 128 clocks; leading filler bits are ones (R2)
    task automatic load_vec(input logic [63:0] pt, input logic [127:0] key);
        for (int i = 0; i < 3; i++) begin
            cnt[i] = 0; cap[i] = '0; lat[i] = 0;
        end
        mode = 1'b1;
        for (int c = 0; c < 128; c++) begin
            for (int i = 0; i < 3; i++) begin
                int ko;
                int to;
                ko = 128 - 4 * nsz[i];
                to = 128 - 2 * nsz[i];
                kbit[i] = (c >= ko) ? key[c - ko] : 1'b1;
                tbit[i] = (c >= to) ? pt[c - to] : 1'b1;
            end
            @(negedge clk);
        end
        mode = 1'b0;
    endtask

    task automatic run_vec(input logic [63:0] pt, input logic [127:0] key, input string tag);
        load_vec(pt, key);
        for (int k = 1; k <= 1500; k++) begin
            @(negedge clk);
            for (int i = 0; i < 3; i++)
                if (v[i] && lat[i] == 0) lat[i] = k;
        end
        for (int i = 0; i < 3; i++) begin
            logic [63:0] exp;
            exp = ref_enc(nsz[i], pt, key);
            check(cap[i] == exp, $sformatf("R2 R3 R4 R5 ciphertext n=%0d %s", nsz[i], tag), cap[i], exp);
            check(cnt[i] == 2 * nsz[i], $sformatf("R7 burst length n=%0d %s", nsz[i], tag),
                  64'(cnt[i]), 64'(2 * nsz[i]));
            check(lat[i] == ((nsz[i] == 16) ? 32 : (nsz[i] == 24) ? 36 : 44) * nsz[i] + 1,
                  $sformatf("R6 first valid n=%0d %s", nsz[i], tag), 64'(lat[i]),
                  64'(((nsz[i] == 16) ? 32 : (nsz[i] == 24) ? 36 : 44) * nsz[i] + 1));
        end
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin
            tbit[i] = 1'b0; kbit[i] = 1'b0; cnt[i] = 0; lat[i] = 0; cap[i] = '0;
        end
        repeat (4) @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            check(v[i] == 1'b0, "R1 valid in reset", 64'(v[i]), 64'd0);
            check(ob[i] == 1'b0, "R1 data in reset", 64'(ob[i]), 64'd0);
        end
        rst = 1'b0;
        // R1: idle with mode low does not start a run
        begin
            bit seen[3] = '{0, 0, 0};
            for (int k = 0; k < 200; k++) begin
                @(negedge clk);
                for (int i = 0; i < 3; i++) if (v[i] || ob[i]) seen[i] = 1'b1;
            end
            for (int i = 0; i < 3; i++)
                check(!seen[i], "R1 idle stays quiet", 64'(seen[i]), 64'd0);
        end

        // Vector table
        for (int t = 0; t < NV; t++)
            run_vec(TXT[t], KEY[t], $sformatf("vec%0d", t));

        // R8: abort during rounds, then reload
        load_vec(TXT[3], KEY[3]);
        begin
            bit seen[3] = '{0, 0, 0};
            for (int k = 0; k < 300; k++) begin
                @(negedge clk);
                for (int i = 0; i < 3; i++) if (v[i] || ob[i]) seen[i] = 1'b1;
            end
            for (int i = 0; i < 3; i++)
                check(!seen[i], "R7 no output during rounds", 64'(seen[i]), 64'd0);
        end
        run_vec(TXT[2], KEY[4], "R8 after abort in rounds");

        // R8: abort in the middle of the n=16 output burst
        load_vec(TXT[4], KEY[2]);
        repeat (520) @(negedge clk);
        check(v[0] == 1'b1, "R7 valid mid burst n=16", 64'(v[0]), 64'd1);
        mode = 1'b1;
        @(negedge clk);
        check(v[0] == 1'b0, "R8 valid drops after load clock", 64'(v[0]), 64'd0);
        mode = 1'b0;
        @(negedge clk);
        run_vec(TXT[1], KEY[2], "R8 after abort in output");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule